// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block merges up to 32 interrupt lines into a single request to a processor. Each line is captured into a status register. A line can be configured to capture on a rising edge or to follow a high level. Captured requests are masked by an enable register, and the processor can acknowledge them one bit at a time.

Software changes the enable mask in one of three ways: it can load the whole mask, set bits through a write-one-to-set port, or clear bits through a write-one-to-clear port. The two port writes need no read-modify-write, so masking from several contexts stays atomic. A vector register gives the number of the lowest pending source, and the processor uses it directly as its interrupt number.

The processor request output is driven only while both bits of a two-bit master enable register are set. Software reaches the block through a simple word-wide register bus with a write strobe and a read strobe. Read data is registered.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Word registers sit at byte offsets 0x00 status (read only), 0x04 pending (read only), 0x08 enable (read/write), 0x0C acknowledge (write only, reads 0), 0x10 set-enable and 0x14 clear-enable (write only, read 0), 0x18 vector (read only) and 0x1C master enable (bits 1:0, read/write). Read data appears on `rdData` in the cycle after the clock edge that samples `rdEn`, and it holds until the next read.
- R2: After reset, status, enable and master enable are 0, `irqOut` is 0, and the vector register reads 0xFFFFFFFF.
- R3: A write to 0x08 loads the enable register with the written mask. Writing 0 there disables every source.
- R4: A write to 0x10 ORs the written mask into the enable register. Zero bits leave their enable bits unchanged.
- R5: A write to 0x14 clears each enable bit that is 1 in the written mask. Zero bits leave their enable bits unchanged.
- R6: An edge-configured source (EDGE_MASK bit = 1) sets its status bit one clock after its line rises. The bit stays set after the line falls, until it is acknowledged. A line that stays high after the acknowledge does not set the bit again.
- R7: A level-configured source (EDGE_MASK bit = 0) sets its status bit in every cycle its line is high, so an acknowledge written while the line is high leaves the bit set. Once the line is low, an acknowledge clears the bit.
- R8: Writing 1 to a bit at 0x0C clears that status bit, and zero bits leave status unchanged. Writing 0xFFFFFFFF clears every latched request.
- R9: Pending (0x04) equals status AND enable.
- R10: The vector register returns the index of the lowest-numbered pending bit, zero-extended to 32 bits, or 0xFFFFFFFF when nothing is pending.
- R11: `irqOut` is high exactly when pending is non-zero and master enable bit 0 (output enable) and bit 1 (hardware input enable) are both 1.
- R12: Data bits at or above NUM_SRC are ignored on writes and read as 0 in status, pending and enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register; word aligned |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqLines | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| irqOut | output | 1 | Combined interrupt request to the processor |

## Verification
The bench builds the block with NUM_SRC = 8 and EDGE_MASK = 0x0F. Sources 0 to 3 are therefore edge captured and sources 4 to 7 are level captured, so one run covers both acknowledge rules. The eight-bit width leaves bits 8 to 31 of the bus unused, and a write of all ones shows that those bits read back as zero. The vector is checked with edge and level sources pending at the same time, and again as the enable register removes them one by one down to the empty case.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int MASTER_W = 2;
  localparam int ME_BIT   = 0;  // output enable
  localparam int HIE_BIT  = 1;  // hardware input enable

  // Word index of each register; the decoder relies on this order.
  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_PENDING = 3'd1,
    SEL_ENABLE  = 3'd2,
    SEL_ACK     = 3'd3,
    SEL_SETEN   = 3'd4,
    SEL_CLREN   = 3'd5,
    SEL_VECTOR  = 3'd6,
    SEL_MASTER  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    ldEnable;
    logic    ldAck;
    logic    ldSet;
    logic    ldClr;
    logic    ldMaster;
    logic    rdStb;
    regSel_e rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrb_t         strb
);
  logic    aligned;
  regSel_e sel;

  assign aligned = (addr[1:0] == 2'b00);
  assign sel     = regSel_e'(addr[ADDR_W-1:2]);

  always_comb begin
    strb          = '0;
    strb.rdSel    = sel;
    strb.rdStb    = rdEn;
    if (wrEn && aligned) begin
      unique case (sel)
        SEL_ENABLE: strb.ldEnable = 1'b1;
        SEL_ACK:    strb.ldAck    = 1'b1;
        SEL_SETEN:  strb.ldSet    = 1'b1;
        SEL_CLREN:  strb.ldClr    = 1'b1;
        SEL_MASTER: strb.ldMaster = 1'b1;
        default:    ;
      endcase
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ldEnable, strb.ldAck, strb.ldSet, strb.ldClr, strb.ldMaster})); // R1
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.ldEnable | strb.ldAck | strb.ldSet | strb.ldClr | strb.ldMaster)); // R1
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IDX_W-1:0];
    end
  end

  assign found = |req;
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_SRC-1:0] lines,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]  statusQ, enableQ, lineQ;
  logic [NUM_SRC-1:0]  statusD, enableD, captHit;
  logic [NUM_SRC-1:0]  wrMask, ackMask, pending;
  logic [MASTER_W-1:0] masterQ;
  logic                vecFound;
  logic [IDX_W-1:0]    vecIdx;
  logic [DATA_W-1:0]   vector, rdMux, rdDataQ;

  assign wrMask  = wrData[NUM_SRC-1:0];
  assign ackMask = strb.ldAck ? wrMask : '0;

  // Capture rule for each source; the parameter picks edge or level logic.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gCapt
    if (EDGE_MASK[g]) begin : gEdge
      assign captHit[g] = lines[g] & ~lineQ[g];
    end else begin : gLevel
      assign captHit[g] = lines[g];
    end
  end

  // New captures win over an acknowledge in the same cycle.
  assign statusD = (statusQ & ~ackMask) | captHit;

  always_comb begin
    enableD = enableQ;
    if (strb.ldEnable)   enableD = wrMask;
    else if (strb.ldSet) enableD = enableQ | wrMask;
    else if (strb.ldClr) enableD = enableQ & ~wrMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      lineQ   <= '0;
      masterQ <= '0;
    end else begin
      statusQ <= statusD;
      enableQ <= enableD;
      lineQ   <= lines;
      if (strb.ldMaster) masterQ <= wrData[MASTER_W-1:0];
    end
  end

  assign pending = statusQ & enableQ;

  irqc_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) uEnc (
    .req   (pending),
    .found (vecFound),
    .idx   (vecIdx)
  );

  always_comb begin
    vector = '1;
    if (vecFound) begin
      vector             = '0;
      vector[IDX_W-1:0]  = vecIdx;
    end
  end

  assign irqOut = (|pending) & masterQ[ME_BIT] & masterQ[HIE_BIT];

  always_comb begin
    rdMux = '0;
    unique case (strb.rdSel)
      SEL_STATUS:  rdMux[NUM_SRC-1:0]  = statusQ;
      SEL_PENDING: rdMux[NUM_SRC-1:0]  = pending;
      SEL_ENABLE:  rdMux[NUM_SRC-1:0]  = enableQ;
      SEL_VECTOR:  rdMux               = vector;
      SEL_MASTER:  rdMux[MASTER_W-1:0] = masterQ;
      default:     rdMux               = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdDataQ <= '0;
    else if (strb.rdStb) rdDataQ <= rdMux;
  end

  assign rdData = rdDataQ;

  // Enable register update rules
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldEnable |=> (enableQ == $past(wrMask))); // R3
  AST_SET_OR: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSet |=> ((enableQ & $past(enableQ | wrMask)) == $past(enableQ | wrMask))); // R4
  AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldClr |=> ((enableQ & $past(wrMask)) == '0)); // R5

  // Capture and acknowledge
  AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|(lines & ~lineQ & EDGE_MASK)) |=>
      ((statusQ & $past(lines & ~lineQ & EDGE_MASK)) == $past(lines & ~lineQ & EDGE_MASK))); // R6
  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|(lines & ~EDGE_MASK)) |=>
      ((statusQ & $past(lines & ~EDGE_MASK)) == $past(lines & ~EDGE_MASK))); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & ~ackMask)) |=>
      ((statusQ & $past(statusQ & ~ackMask)) == $past(statusQ & ~ackMask))); // R8

  // Vector and output
  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0) |-> (vector == '1)); // R10
  AST_VEC_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (pending != '0) |-> (pending[vecIdx] &&
      ((pending & ((NUM_SRC'(1) << vecIdx) - NUM_SRC'(1))) == '0))); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (masterQ == 2'b11 && pending != '0)); // R11
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,  // 1 to 32
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '1   // 1 = edge, 0 = level
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [4:0]         addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] irqLines,
  output logic               irqOut
);
  ctrlStrb_t strb;

  irqc_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .lines  (irqLines),
    .rdData (rdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  localparam int NSRC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NSRC-1:0] lines = '0;
  logic        irqOut;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_vector_ctrl #(.NUM_SRC(NSRC), .EDGE_MASK(8'h0F)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqLines(lines), .irqOut(irqOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setLines(input logic [NSRC-1:0] v);
    @(negedge clk);
    lines = v;
  endtask

  task automatic tReset();
    logic [31:0] d;
    chk("R2", "irqOut after reset", {31'b0, irqOut}, 32'h0);
    busRd(5'h00, d); chk("R2", "status reset", d, 32'h0);
    busRd(5'h04, d); chk("R2", "pending reset", d, 32'h0);
    busRd(5'h08, d); chk("R2", "enable reset", d, 32'h0);
    busRd(5'h1C, d); chk("R2", "master reset", d, 32'h0);
    busRd(5'h18, d); chk("R2", "vector reset", d, 32'hFFFF_FFFF);
  endtask

  task automatic tEnable();
    logic [31:0] d;
    busWr(5'h08, 32'h0000_00A5); busRd(5'h08, d); chk("R3", "enable load", d, 32'hA5);
    busWr(5'h08, 32'hFFFF_FFFF); busRd(5'h08, d); chk("R12", "enable upper bits", d, 32'hFF);
    busWr(5'h08, 32'h0);         busRd(5'h08, d); chk("R3", "enable zero", d, 32'h0);
  endtask

  task automatic tSetClr();
    logic [31:0] d;
    busWr(5'h08, 32'h0F);
    busWr(5'h10, 32'h30); busRd(5'h08, d); chk("R4", "set-enable OR", d, 32'h3F);
    busWr(5'h14, 32'h05); busRd(5'h08, d); chk("R5", "clear-enable", d, 32'h3A);
    busWr(5'h10, 32'h00); busRd(5'h08, d); chk("R4", "set zero mask", d, 32'h3A);
    busWr(5'h14, 32'h00); busRd(5'h08, d); chk("R5", "clear zero mask", d, 32'h3A);
    busRd(5'h10, d); chk("R1", "set-enable reads 0", d, 32'h0);
    busWr(5'h08, 32'h0);
  endtask

  task automatic tEdge();
    logic [31:0] d;
    setLines(8'h01); setLines(8'h00);
    busRd(5'h00, d); chk("R6", "edge pulse latched", d, 32'h01);
    setLines(8'h02);
    busRd(5'h00, d); chk("R6", "second edge", d, 32'h03);
    busWr(5'h0C, 32'h02);
    busRd(5'h00, d); chk("R8", "ack one bit, held edge line", d, 32'h01);
    setLines(8'h00);
    busWr(5'h0C, 32'hFFFF_FFFF);
    busRd(5'h00, d); chk("R8", "ack all", d, 32'h0);
  endtask

  task automatic tLevel();
    logic [31:0] d;
    setLines(8'h20);
    busRd(5'h00, d); chk("R7", "level set", d, 32'h20);
    busWr(5'h0C, 32'h20);
    busRd(5'h00, d); chk("R7", "ack while high", d, 32'h20);
    setLines(8'h00);
    busWr(5'h0C, 32'h20);
    busRd(5'h00, d); chk("R7", "ack after low", d, 32'h0);
  endtask

  task automatic tVector();
    logic [31:0] d;
    setLines(8'h0C); setLines(8'h40);
    busRd(5'h00, d); chk("R6", "mixed status", d, 32'h4C);
    busWr(5'h08, 32'h48);
    busRd(5'h04, d); chk("R9", "pending masked", d, 32'h48);
    busRd(5'h18, d); chk("R10", "vector lowest", d, 32'd3);
    busWr(5'h14, 32'h08);
    busRd(5'h18, d); chk("R10", "vector next", d, 32'd6);
    busWr(5'h14, 32'h40);
    busRd(5'h04, d); chk("R9", "pending none", d, 32'h0);
    busRd(5'h18, d); chk("R10", "vector empty", d, 32'hFFFF_FFFF);
  endtask

  task automatic tIrq();
    logic [31:0] d;
    busWr(5'h08, 32'h40);
    busWr(5'h1C, 32'h0); chk("R11", "irq master 0", {31'b0, irqOut}, 32'h0);
    busWr(5'h1C, 32'h1); chk("R11", "irq ME only", {31'b0, irqOut}, 32'h0);
    busWr(5'h1C, 32'h2); chk("R11", "irq HIE only", {31'b0, irqOut}, 32'h0);
    busWr(5'h1C, 32'h3); chk("R11", "irq both", {31'b0, irqOut}, 32'h1);
    busRd(5'h1C, d); chk("R1", "master readback", d, 32'h3);
    busRd(5'h0C, d); chk("R1", "ack reads 0", d, 32'h0);
    busWr(5'h08, 32'h0); chk("R11", "irq enable off", {31'b0, irqOut}, 32'h0);
    setLines(8'h00);
    busWr(5'h0C, 32'hFFFF_FFFF);
    busRd(5'h00, d); chk("R8", "final clear", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEnable();
    tSetClr();
    tEdge();
    tLevel();
    tVector();
    tIrq();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule